// File: doc/BRIEF.md
# Flow QoS Escalation Controller

This block keeps a priority level for each of a fixed set of producer-to-consumer communication flows. A monitor hands it one record per delivered message. The record carries the task identifier of the flow, the measured latency in cycles and the message size. The controller compares the record with that flow's latency ceiling and throughput floor, which are held on static input buses. It counts the violations it finds. When enough violations have gathered, it emits a priority-change command that raises the flow's level.

Each flow sits at one of three levels: low priority, high priority and guaranteed throughput. A flow moves up by one step after repeated latency misses. A throughput miss in the window sends it straight to guaranteed throughput. When a flow reaches guaranteed throughput, the controller also requests a dedicated circuit between that flow's producer and consumer. Both outputs use a valid/ready handshake. While either one is pending, no new record is accepted.

Top module: `flow_qos_ctrl`

## Requirements
- R1: After reset every flow is at level 0 (low), `cmd_valid_o` and `circ_valid_o` are low, and `rec_ready_o` is high. Level codes are 0 = low, 1 = high, 2 = guaranteed; `level_o` holds flow i in bits [2i+1:2i].
- R2: A record is taken on a clock edge where `rec_valid_i` and `rec_ready_o` are both high. It is a latency violation when its latency is strictly greater than the flow's ceiling, which sits at `lat_limit_i[i*LAT_W +: LAT_W]`.
- R3: A record is a throughput violation when size * 2^FRAC is less than floor * latency. The floor sits at `tput_limit_i[i*TP_W +: TP_W]` and is in fixed point with FRAC fraction bits. A record with latency 0 is never a throughput violation. A record that violates both limits counts as one violation.
- R4: A flow issues a command only on the record that brings its violation count to THRESH. Records without a violation leave the count unchanged.
- R5: When no throughput violation is in the window, the command raises the level by exactly one step: low to high, then high to guaranteed.
- R6: When any of the violations counted in the window was a throughput violation, the command sets the level to guaranteed, whatever the current level.
- R7: Issuing a command clears that flow's violation count and its throughput mark.
- R8: Records for a flow already at guaranteed are accepted but produce no command and no circuit request.
- R9: A command that sets the level to guaranteed also raises `circ_valid_o` with `circ_flow_o` equal to the flow. The request stays up until `circ_ready_i` is seen.
- R10: `cmd_valid_o` rises in the cycle after the triggering record is accepted. It holds its flow and level stable until `cmd_ready_i`. `rec_ready_o` is low while a command or a circuit request is pending.
- R11: Records for one flow never change the level or count of another flow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rec_valid_i | input | 1 | Monitoring record valid |
| rec_ready_o | output | 1 | Record can be accepted |
| rec_task_i | input | FLOW_W | Task identifier selecting the flow |
| rec_lat_i | input | LAT_W | Measured message latency in cycles |
| rec_size_i | input | SIZE_W | Message size |
| lat_limit_i | input | NUM_FLOWS*LAT_W | Per-flow latency ceilings |
| tput_limit_i | input | NUM_FLOWS*TP_W | Per-flow throughput floors, fixed point |
| cmd_valid_o | output | 1 | Priority-change command valid |
| cmd_ready_i | input | 1 | Command taken |
| cmd_flow_o | output | FLOW_W | Flow of the command |
| cmd_level_o | output | 2 | New level of the flow |
| circ_valid_o | output | 1 | Circuit open request valid |
| circ_ready_i | input | 1 | Circuit request taken |
| circ_flow_o | output | FLOW_W | Flow for which the circuit is opened |
| level_o | output | NUM_FLOWS*2 | Current level of every flow |

## Verification
The bench builds the block with four flows, THRESH of 2 and FRAC of 4. With a threshold of 2, every escalation path fits in a few records: a flow goes from low to guaranteed in four latency violations. It also allows a window that mixes one latency miss with one throughput miss. The fractional floors of 0.5 to 2 bytes per cycle put random sizes and latencies on both sides of the throughput comparison. The ceilings of 200 to 500 cycles do the same for the latency comparison. Directed records cover the exact latency boundary, latency zero, the double violation and records sent to flows that are already guaranteed.

// File: rtl/qos_pkg.sv
package qos_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_HIGH = 2'd1,
    LVL_GT   = 2'd2
  } qos_level_e;
endpackage

// File: rtl/qos_rec_check.sv
module qos_rec_check #(
  parameter int LAT_W  = 12,
  parameter int SIZE_W = 12,
  parameter int TP_W   = 8,
  parameter int FRAC   = 4
) (
  input  logic [LAT_W-1:0]  lat_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [LAT_W-1:0]  lat_lim_i,
  input  logic [TP_W-1:0]   tp_lim_i,
  output logic              lat_viol_o,
  output logic              tp_viol_o
);
  localparam int LW = SIZE_W + FRAC;
  localparam int RW = TP_W + LAT_W;
  localparam int PW = ((LW > RW) ? LW : RW) + 1;

  logic [PW-1:0] lhs, rhs;

  always_comb begin
    lhs = PW'(size_i) << FRAC;
    rhs = PW'(tp_lim_i) * PW'(lat_i);   // cross-multiplied rate check
    tp_viol_o  = lhs < rhs;
    lat_viol_o = lat_i > lat_lim_i;
  end
endmodule

// File: rtl/qos_flow_state.sv
module qos_flow_state
  import qos_pkg::*;
#(
  parameter int THRESH = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hit_i,
  input  logic       lat_viol_i,
  input  logic       tp_viol_i,
  output qos_level_e level_o,
  output logic       fire_o,
  output qos_level_e new_level_o
);
  localparam int CNT_W = $clog2(THRESH + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tp_mark_q;
  qos_level_e       level_q;
  logic             viol;

  assign viol   = hit_i && (lat_viol_i || tp_viol_i) && (level_q != LVL_GT);
  assign fire_o = viol && (cnt_q == CNT_W'(THRESH - 1));

  always_comb begin
    if (tp_mark_q || tp_viol_i) new_level_o = LVL_GT;
    else if (level_q == LVL_LOW) new_level_o = LVL_HIGH;
    else new_level_o = LVL_GT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      tp_mark_q <= 1'b0;
      level_q   <= LVL_LOW;
    end else if (fire_o) begin
      cnt_q     <= '0;
      tp_mark_q <= 1'b0;
      level_q   <= new_level_o;
    end else if (viol) begin
      cnt_q     <= cnt_q + 1'b1;
      tp_mark_q <= tp_mark_q | tp_viol_i;
    end
  end

  assign level_o = level_q;

  p_level_monotone_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> level_q >= $past(level_q));
  p_level_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q != 2'd3);
  p_cnt_below_thresh_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(THRESH));
  p_idle_keeps_level_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> $stable(level_q));
  p_gt_no_fire_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q == LVL_GT) |-> !fire_o);
endmodule

// File: rtl/qos_cmd_out.sv
module qos_cmd_out
  import qos_pkg::*;
#(
  parameter int FLOW_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [FLOW_W-1:0] fire_flow_i,
  input  qos_level_e        fire_level_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [FLOW_W-1:0] cmd_flow_o,
  output qos_level_e        cmd_level_o,
  output logic              circ_valid_o,
  input  logic              circ_ready_i,
  output logic [FLOW_W-1:0] circ_flow_o,
  output logic              busy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o  <= 1'b0;
      cmd_flow_o   <= '0;
      cmd_level_o  <= LVL_LOW;
      circ_valid_o <= 1'b0;
      circ_flow_o  <= '0;
    end else begin
      if (fire_i) begin
        cmd_valid_o <= 1'b1;
        cmd_flow_o  <= fire_flow_i;
        cmd_level_o <= fire_level_i;
      end else if (cmd_ready_i) begin
        cmd_valid_o <= 1'b0;
      end
      if (fire_i && fire_level_i == LVL_GT) begin
        circ_valid_o <= 1'b1;
        circ_flow_o  <= fire_flow_i;
      end else if (circ_ready_i) begin
        circ_valid_o <= 1'b0;
      end
    end
  end

  assign busy_o = cmd_valid_o || circ_valid_o;

  p_cmd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_flow_o) && $stable(cmd_level_o));
  p_circ_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    circ_valid_o && !circ_ready_i |=> circ_valid_o && $stable(circ_flow_o));
  p_circ_with_gt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(circ_valid_o) |-> cmd_valid_o && cmd_level_o == LVL_GT && cmd_flow_o == circ_flow_o);
endmodule

// File: rtl/flow_qos_ctrl.sv
module flow_qos_ctrl
  import qos_pkg::*;
#(
  parameter int NUM_FLOWS = 4,
  parameter int LAT_W     = 12,
  parameter int SIZE_W    = 12,
  parameter int TP_W      = 8,
  parameter int FRAC      = 4,
  parameter int THRESH    = 3,
  localparam int FLOW_W   = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rec_valid_i,
  output logic                      rec_ready_o,
  input  logic [FLOW_W-1:0]         rec_task_i,
  input  logic [LAT_W-1:0]          rec_lat_i,
  input  logic [SIZE_W-1:0]         rec_size_i,
  input  logic [NUM_FLOWS*LAT_W-1:0] lat_limit_i,
  input  logic [NUM_FLOWS*TP_W-1:0] tput_limit_i,
  output logic                      cmd_valid_o,
  input  logic                      cmd_ready_i,
  output logic [FLOW_W-1:0]         cmd_flow_o,
  output logic [1:0]                cmd_level_o,
  output logic                      circ_valid_o,
  input  logic                      circ_ready_i,
  output logic [FLOW_W-1:0]         circ_flow_o,
  output logic [NUM_FLOWS*2-1:0]    level_o
);
  logic              take, busy, lat_viol, tp_viol;
  logic [LAT_W-1:0]  lat_lim;
  logic [TP_W-1:0]   tp_lim;
  logic [NUM_FLOWS-1:0] fire;
  qos_level_e        new_lvl [NUM_FLOWS];
  qos_level_e        fire_lvl, cmd_lvl;
  logic [FLOW_W-1:0] fire_flow;

  assign rec_ready_o = !busy;
  assign take        = rec_valid_i && rec_ready_o;

  always_comb begin
    lat_lim = '0;
    tp_lim  = '0;
    for (int i = 0; i < NUM_FLOWS; i++) begin
      if (rec_task_i == FLOW_W'(i)) begin
        lat_lim = lat_limit_i[i*LAT_W +: LAT_W];
        tp_lim  = tput_limit_i[i*TP_W +: TP_W];
      end
    end
  end

  qos_rec_check #(.LAT_W(LAT_W), .SIZE_W(SIZE_W), .TP_W(TP_W), .FRAC(FRAC)) u_check (
    .lat_i(rec_lat_i), .size_i(rec_size_i), .lat_lim_i(lat_lim), .tp_lim_i(tp_lim),
    .lat_viol_o(lat_viol), .tp_viol_o(tp_viol)
  );

  for (genvar g = 0; g < NUM_FLOWS; g++) begin : g_flow
    qos_level_e lvl;
    qos_flow_state #(.THRESH(THRESH)) u_state (
      .clk_i, .rst_ni,
      .hit_i(take && rec_task_i == FLOW_W'(g)),
      .lat_viol_i(lat_viol), .tp_viol_i(tp_viol),
      .level_o(lvl), .fire_o(fire[g]), .new_level_o(new_lvl[g])
    );
    assign level_o[2*g +: 2] = lvl;
  end

  always_comb begin
    fire_flow = '0;
    fire_lvl  = LVL_LOW;
    for (int i = 0; i < NUM_FLOWS; i++) begin
      if (fire[i]) begin
        fire_flow = FLOW_W'(i);
        fire_lvl  = new_lvl[i];
      end
    end
  end

  qos_cmd_out #(.FLOW_W(FLOW_W)) u_out (
    .clk_i, .rst_ni,
    .fire_i(|fire), .fire_flow_i(fire_flow), .fire_level_i(fire_lvl),
    .cmd_valid_o, .cmd_ready_i, .cmd_flow_o, .cmd_level_o(cmd_lvl),
    .circ_valid_o, .circ_ready_i, .circ_flow_o, .busy_o(busy)
  );
  assign cmd_level_o = cmd_lvl;

  p_one_fire_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fire));
  p_hold_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o || circ_valid_o) |-> !rec_ready_o);
  p_cmd_after_take_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_valid_o) |-> $past(take));
endmodule

// File: tb/flow_qos_ctrl_test.sv
module flow_qos_ctrl_test;
  localparam int NF = 4, LW = 12, SW = 12, TW = 8, FR = 4, TH = 2, FW = 2;

  logic clk = 0, rst_n = 0;
  logic rec_valid = 0, cmd_ready = 0, circ_ready = 0;
  logic [FW-1:0] rec_task = 0;
  logic [LW-1:0] rec_lat = 0;
  logic [SW-1:0] rec_size = 0;
  logic [NF*LW-1:0] lat_lim;
  logic [NF*TW-1:0] tp_lim;
  logic rec_ready, cmd_valid, circ_valid;
  logic [FW-1:0] cmd_flow, circ_flow;
  logic [1:0] cmd_level;
  logic [NF*2-1:0] level;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_lvl [NF];
  int m_cnt [NF];
  bit m_tp  [NF];
  int lim_l [NF] = '{200, 300, 400, 500};
  int lim_t [NF] = '{16, 32, 8, 24};

  always #10 clk = ~clk;

  flow_qos_ctrl #(.NUM_FLOWS(NF), .LAT_W(LW), .SIZE_W(SW), .TP_W(TW), .FRAC(FR), .THRESH(TH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rec_valid_i(rec_valid), .rec_ready_o(rec_ready),
    .rec_task_i(rec_task), .rec_lat_i(rec_lat), .rec_size_i(rec_size),
    .lat_limit_i(lat_lim), .tput_limit_i(tp_lim),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_flow_o(cmd_flow), .cmd_level_o(cmd_level),
    .circ_valid_o(circ_valid), .circ_ready_i(circ_ready), .circ_flow_o(circ_flow), .level_o(level)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit f_lat_viol(int f, int lat);
    return lat > lim_l[f];
  endfunction

  function automatic bit f_tp_viol(int f, int lat, int size);
    return (longint'(size) << FR) < longint'(lim_t[f]) * lat;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NF; i++) begin m_lvl[i] = 0; m_cnt[i] = 0; m_tp[i] = 0; end
  endtask

  task automatic check_levels(string req);
    for (int i = 0; i < NF; i++) chk(level[2*i +: 2] == m_lvl[i], req, level[2*i +: 2], m_lvl[i]);
  endtask

  task automatic send(int f, int lat, int size, string req);
    bit lv, tv, exp_cmd;
    int nl;
    lv = f_lat_viol(f, lat);
    tv = f_tp_viol(f, lat, size);
    exp_cmd = 0; nl = m_lvl[f];
    if (m_lvl[f] != 2 && (lv || tv)) begin
      if (tv) m_tp[f] = 1;
      m_cnt[f]++;
      if (m_cnt[f] == TH) begin
        nl = m_tp[f] ? 2 : m_lvl[f] + 1;
        exp_cmd = 1; m_lvl[f] = nl; m_cnt[f] = 0; m_tp[f] = 0;
      end
    end
    chk(rec_ready == 1, "R10 ready before record", rec_ready, 1);
    rec_task = FW'(f); rec_lat = LW'(lat); rec_size = SW'(size); rec_valid = 1;
    @(negedge clk);
    rec_valid = 0;
    chk(cmd_valid == exp_cmd, {req, " cmd_valid"}, cmd_valid, exp_cmd);
    if (exp_cmd) begin
      chk(cmd_flow == FW'(f), {req, " cmd_flow"}, cmd_flow, f);
      chk(cmd_level == 2'(nl), {req, " cmd_level"}, cmd_level, nl);
      chk(circ_valid == (nl == 2), "R9 circuit request", circ_valid, nl == 2);
      if (nl == 2) chk(circ_flow == FW'(f), "R9 circuit flow", circ_flow, f);
      chk(rec_ready == 0, "R10 hold off", rec_ready, 0);
      for (int w = 0; w < int'($urandom_range(0, 2)); w++) begin
        @(negedge clk);
        chk(cmd_valid && cmd_flow == FW'(f) && cmd_level == 2'(nl), "R10 stable", cmd_level, nl);
      end
      cmd_ready = 1; @(negedge clk); cmd_ready = 0;
      chk(cmd_valid == 0, "R10 cmd drop", cmd_valid, 0);
      if (nl == 2) begin
        chk(circ_valid == 1 && rec_ready == 0, "R9 circuit held", circ_valid, 1);
        circ_ready = 1; @(negedge clk); circ_ready = 0;
        chk(circ_valid == 0, "R9 circuit drop", circ_valid, 0);
      end
    end else begin
      chk(circ_valid == 0, "R8 no circuit", circ_valid, 0);
    end
    check_levels("R11 levels");
  endtask

  initial begin
    for (int i = 0; i < NF; i++) begin
      lat_lim[i*LW +: LW] = LW'(lim_l[i]);
      tp_lim[i*TW +: TW]  = TW'(lim_t[i]);
    end
    void'($urandom(1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_valid == 0 && circ_valid == 0, "R1 outputs idle", cmd_valid, 0);
    chk(rec_ready == 1, "R1 ready", rec_ready, 1);
    check_levels("R1 levels");

    // R2 boundary: latency equal to ceiling is fine; size big enough to avoid R3
    send(0, 200, 4000, "R2 at limit");
    send(0, 200, 4000, "R4 no count");
    send(0, 201, 4000, "R4 first viol");
    send(0, 201, 4000, "R5 low to high");
    send(0, 900, 4000, "R7 count cleared");
    send(0, 900, 4000, "R5 high to gt");
    send(0, 900, 1, "R8 gt ignored");
    send(0, 900, 1, "R8 gt ignored again");
    // R3: flow 1 floor 2 B/cycle; lat 0 never violates
    send(1, 0, 0, "R3 latency zero");
    send(1, 100, 200, "R3 at floor");
    send(1, 100, 199, "R3 below floor");
    send(1, 10, 4000, "R4 second hit");
    chk(m_lvl[1] == 0, "R3 model", m_lvl[1], 0);
    send(1, 100, 199, "R6 throughput window");
    send(1, 100, 150, "R6 jump to gt");
    // R6: one tp + one lat at high still goes gt; double violation counts once
    send(2, 401, 4000, "R5 flow2 a");
    send(2, 401, 4000, "R5 flow2 b");
    send(2, 450, 10, "R3 double counts once");
    send(2, 450, 4000, "R6 mark from window");
    send(3, 100, 1, "R6 from low a");
    send(3, 100, 1, "R6 from low b");

    rst_n = 0; @(negedge clk); rst_n = 1; model_reset(); @(negedge clk);
    check_levels("R1 after reset");

    for (int k = 0; k < 300; k++) begin
      int f, lat, size;
      f = $urandom_range(0, NF - 1);
      lat = $urandom_range(0, 700);
      size = $urandom_range(0, 1200);
      send(f, lat, size, "R4 random");
      if (k % 60 == 59) begin
        rst_n = 0; @(negedge clk); rst_n = 1; model_reset(); @(negedge clk);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule